// File: doc/BRIEF.md
# Serial Management Frame Master

This block issues clause-22 style management transactions to an external PHY over a two-wire serial management interface. A client raises a one-cycle request with a read/write flag, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit data word. The block then produces the whole frame on its own. It drives the management clock, the serial data output and the output enable for the tristate data pad, and it samples the returned data input.

Each bit time has a low clock phase and a high clock phase, and each phase lasts `DIV` system clocks. The outgoing data changes only when a low phase begins. The incoming data is captured on the system clock edge that drives the management clock high. A read frame is one bit time shorter than a write frame, because only one released turnaround bit comes before the PHY's data. When a frame ends, `done_o` pulses for one cycle. On a read, the 16 captured bits appear on `rdata_o` in that same cycle.

Top module: `mdio_frame_master`

## Requirements
- R1: A synchronous active-high reset, even one applied in the middle of a frame, leaves the management clock, data output, output enable, busy and done all at 0.
- R2: A frame opens with 32 bit times in which the data output is 1 and the output enable is 1.
- R3: After the opening run comes a driven start code of 0 then 1, and then a driven opcode: 1,0 for a read (`rd_i`=1) and 0,1 for a write (`rd_i`=0).
- R4: The PHY address is driven next, most significant bit first, and then the register number, also most significant bit first.
- R5: A write frame continues with two released bit times (output enable 0), then 16 driven data bits MSB first, then one released bit time. The write frame is 65 bit times long in total.
- R6: A read frame continues with one released bit time, then 16 released bit times in which the input is sampled MSB first, then one released bit time. The read frame is 64 bit times long, and the sampled word appears on `rdata_o` while `done_o` is 1.
- R7: The low and the high clock phase of each bit time each last exactly `DIV` system clocks. Data output and output enable never change while the management clock is high.
- R8: Whenever no frame is in progress, including the cycle in which `done_o` pulses, the clock, the data output and the output enable are all 0.
- R9: A request is accepted only when busy is 0. Busy rises on the edge that accepts the request and stays 1 until the edge that raises `done_o`. Requests made while busy is 1 start no frame and do not change the frame in progress.
- R10: `done_o` is 1 for exactly one cycle at the end of every frame, read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a transaction (taken when not busy) |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_i | input | 5 | Target PHY address |
| reg_i | input | 5 | Target register number |
| wdata_i | input | 16 | Data word for a write |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Word captured by the last read |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data output |
| mdo_oe_o | output | 1 | Output enable for the data pad |
| mdi_i | input | 1 | Serial data input |

## Verification
The hardest situation to reach from the ports is a read whose sampled bits are aligned to exactly the right clock edges. The returned word must be presented by a PHY that follows the frame bit by bit. The bench therefore models the PHY: it counts management-clock rising edges, and while the clock is low it puts the bit for the current position on the data input. Any shift of one bit in the sampling window then shows up in the captured word. Three other cases are also hard to reach, and each has its own stimulus. A request made in the middle of a frame is driven during a write, and the bench then checks that no extra clock edges follow. A request is issued in the first cycle after `done_o`, which exercises immediate re-acceptance. A reset is applied in the middle of a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FIELD_W  = 5;
    localparam int WORD_W   = 16;
    localparam int PRE_BITS = 32;
    localparam int IDX_W    = 7;

    // first bit index after the register-number field
    localparam int HDR_END       = PRE_BITS + 4 + 2 * FIELD_W;
    localparam int RD_DATA_FIRST = HDR_END + 1;
    localparam int RD_LAST       = HDR_END + 1 + WORD_W;
    localparam int WR_LAST       = HDR_END + 2 + WORD_W;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    typedef struct packed {
        logic                rd;
        logic [FIELD_W-1:0]  phy;
        logic [FIELD_W-1:0]  regn;
        logic [WORD_W-1:0]   wdata;
    } mgmt_cmd_t;

    typedef struct packed {
        logic oe;
        logic dout;
    } line_drive_t;

    // Drive value of the data line for bit position idx of a frame
    function automatic line_drive_t frame_bit(mgmt_cmd_t c, logic [IDX_W-1:0] idx);
        int                      i;
        logic [2*FIELD_W-1:0]    hdr;
        line_drive_t             r;
        i   = int'(idx);
        hdr = {c.phy, c.regn};
        r   = '{oe: 1'b0, dout: 1'b0};
        if (i < PRE_BITS)
            r = '{oe: 1'b1, dout: 1'b1};
        else if (i == PRE_BITS)
            r = '{oe: 1'b1, dout: 1'b0};
        else if (i == PRE_BITS + 1)
            r = '{oe: 1'b1, dout: 1'b1};
        else if (i == PRE_BITS + 2)
            r = '{oe: 1'b1, dout: c.rd};
        else if (i == PRE_BITS + 3)
            r = '{oe: 1'b1, dout: !c.rd};
        else if (i < HDR_END)
            r = '{oe: 1'b1, dout: hdr[4'(HDR_END - 1 - i)]};
        else if (!c.rd && (i >= HDR_END + 2) && (i < WR_LAST))
            r = '{oe: 1'b1, dout: c.wdata[4'(WR_LAST - 1 - i)]};
        return r;
    endfunction

endpackage

// File: rtl/mgmt_phase_timer.sv
module mgmt_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic wrap_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign wrap_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || wrap_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R7: the phase counter never passes the programmed length
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: the counter is held at zero while no frame runs
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_i) sh_d = {sh_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign word_o = sh_q;

    // R6: the captured word moves only when a sample is taken
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(shift_i) |-> $stable(sh_q));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic               rd_i,
    input  logic [FIELD_W-1:0] phy_i,
    input  logic [FIELD_W-1:0] reg_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               mdc_o,
    output logic               mdo_o,
    output logic               mdo_oe_o,
    input  logic               mdi_i
);
    localparam logic [IDX_W-1:0] RD_LAST_IDX  = IDX_W'(RD_LAST);
    localparam logic [IDX_W-1:0] WR_LAST_IDX  = IDX_W'(WR_LAST);
    localparam logic [IDX_W-1:0] RD_FIRST_IDX = IDX_W'(RD_DATA_FIRST);
    localparam logic [IDX_W-1:0] HDR_END_IDX  = IDX_W'(HDR_END);

    typedef struct packed {
        seq_state_e       state;
        mgmt_cmd_t        cmd;
        logic [IDX_W-1:0] idx;
        logic             high;
        logic             mdc;
        logic             mdo;
        logic             oe;
        logic             done;
    } seq_t;

    seq_t d, q;
    logic wrap;
    logic shift_en;
    logic [IDX_W-1:0] last_idx;
    mgmt_cmd_t   new_cmd;
    line_drive_t drv;

    mgmt_phase_timer #(.DIV(DIV)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (q.state == ST_RUN),
        .wrap_o (wrap)
    );

    assign last_idx = q.cmd.rd ? RD_LAST_IDX : WR_LAST_IDX;
    assign new_cmd  = '{rd: rd_i, phy: phy_i, regn: reg_i, wdata: wdata_i};

    // sample on the edge that raises the management clock
    assign shift_en = (q.state == ST_RUN) && wrap && !q.high && q.cmd.rd &&
                      (q.idx >= RD_FIRST_IDX) && (q.idx < RD_LAST_IDX);

    mgmt_rx_shift #(.W(WORD_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift_en),
        .bit_i   (mdi_i),
        .word_o  (rdata_o)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        drv    = '{oe: 1'b0, dout: 1'b0};
        case (q.state)
            ST_IDLE: begin
                if (req_i) begin
                    drv     = frame_bit(new_cmd, '0);
                    d.state = ST_RUN;
                    d.cmd   = new_cmd;
                    d.idx   = '0;
                    d.high  = 1'b0;
                    d.mdc   = 1'b0;
                    d.mdo   = drv.dout;
                    d.oe    = drv.oe;
                end
            end
            ST_RUN: begin
                if (wrap) begin
                    if (!q.high) begin
                        d.high = 1'b1;
                        d.mdc  = 1'b1;
                    end else if (q.idx == last_idx) begin
                        d.state = ST_IDLE;
                        d.high  = 1'b0;
                        d.mdc   = 1'b0;
                        d.mdo   = 1'b0;
                        d.oe    = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        drv    = frame_bit(q.cmd, q.idx + 1'b1);
                        d.idx  = q.idx + 1'b1;
                        d.high = 1'b0;
                        d.mdc  = 1'b0;
                        d.mdo  = drv.dout;
                        d.oe   = drv.oe;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.state == ST_RUN);
    assign done_o   = q.done;
    assign mdc_o    = q.mdc;
    assign mdo_o    = q.mdo;
    assign mdo_oe_o = q.oe;

    // R7: line values are held for the whole high phase
    p_stable_high_r7: assert property (@(posedge clk) disable iff (rst)
        mdc_o |-> $stable(mdo_o) && $stable(mdo_oe_o));

    // R8: idle line is quiet
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mdc_o && !mdo_o && !mdo_oe_o);

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: a frame in progress ends only through done
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> busy_o || done_o);

    // R9: an idle request starts a frame
    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i) |=> busy_o);

    // R6: a read never drives the line after the register field
    p_rd_release_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && q.cmd.rd && q.idx >= HDR_END_IDX) |-> !mdo_oe_o);

    // R5: the bit index stays within the longest frame
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> q.idx <= WR_LAST_IDX);

endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, rd = 1'b0;
    logic [4:0]  phy = '0, rg = '0;
    logic [15:0] wd = '0;
    logic        busy, done, mdc, mdo, oe;
    logic        mdi = 1'b1;
    logic [15:0] rdata;

    always #5 clk = ~clk;

    mdio_frame_master #(.DIV(DIV)) u_mdio_frame_master (
        .clk(clk), .rst(rst), .req_i(req), .rd_i(rd), .phy_i(phy),
        .reg_i(rg), .wdata_i(wd), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .mdc_o(mdc), .mdo_o(mdo), .mdo_oe_o(oe),
        .mdi_i(mdi)
    );

    typedef struct {
        int          len;
        logic [64:0] d;
        logic [64:0] en;
        bit          is_rd;
        logic [15:0] word;
    } frame_t;

    frame_t exp_q[$];
    int checks = 0, errors = 0;
    int rc = 0, hi_cnt = 0, lo_cnt = 0;
    logic prev_mdc = 1'b0, prev_done = 1'b0;

    task automatic check(bit ok, string req_tag, string what,
                         logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int k, bit r);
        if (k < 32) return "R2";
        if (k < 36) return "R3";
        if (k < 46) return "R4";
        return r ? "R6" : "R5";
    endfunction

    // driver: waits for idle, issues one request, pushes the expected frame
    task automatic send(bit r, logic [4:0] a, logic [4:0] g,
                        logic [15:0] w, logic [15:0] phy_word);
        frame_t f;
        while (busy) @(negedge clk);
        f.is_rd = r;
        f.word  = phy_word;
        if (r) begin
            f.len = 64;
            f.d   = {32'hFFFF_FFFF, 4'b0110, a, g, 1'b0, 16'h0, 1'b0, 1'b0};
            f.en  = {{46{1'b1}}, 19'b0};
        end else begin
            f.len = 65;
            f.d   = {32'hFFFF_FFFF, 4'b0101, a, g, 2'b00, w, 1'b0};
            f.en  = {{46{1'b1}}, 2'b00, {16{1'b1}}, 1'b0};
        end
        exp_q.push_back(f);
        req = 1'b1; rd = r; phy = a; rg = g; wd = w;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'h1);
    endtask

    // monitor and PHY model
    always @(negedge clk) begin
        if (rst) begin
            rc = 0; hi_cnt = 0; lo_cnt = 0;
            prev_mdc = 1'b0; prev_done = 1'b0;
            mdi = 1'b1;
        end else begin
            if (busy) begin
                if (mdc) hi_cnt++;
                else     lo_cnt++;
            end
            if (mdc && !prev_mdc) begin
                check(lo_cnt == DIV, "R7", "low phase length", 64'(lo_cnt), 64'(DIV));
                lo_cnt = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "clock edge with no accepted request", 64'(rc), 64'h0);
                end else if (rc < 65) begin
                    check(oe == exp_q[0].en[64-rc], tag_of(rc, exp_q[0].is_rd),
                          $sformatf("enable bit %0d", rc), 64'(oe), 64'(exp_q[0].en[64-rc]));
                    if (exp_q[0].en[64-rc])
                        check(mdo == exp_q[0].d[64-rc], tag_of(rc, exp_q[0].is_rd),
                              $sformatf("data bit %0d", rc), 64'(mdo), 64'(exp_q[0].d[64-rc]));
                end
                rc++;
            end
            if (!mdc && prev_mdc) begin
                check(hi_cnt == DIV, "R7", "high phase length", 64'(hi_cnt), 64'(DIV));
                hi_cnt = 0;
            end
            if (prev_done)
                check(done == 1'b0, "R10", "done width", 64'(done), 64'h0);
            if (done) begin
                check({mdc, mdo, oe} == 3'b000, "R8", "line at frame end", 64'({mdc, mdo, oe}), 64'h0);
                check(busy == 1'b0, "R9", "busy at done", 64'(busy), 64'h0);
                if (exp_q.size() > 0) begin
                    check(rc == exp_q[0].len, exp_q[0].is_rd ? "R6" : "R5",
                          "frame length", 64'(rc), 64'(exp_q[0].len));
                    if (exp_q[0].is_rd)
                        check(rdata == exp_q[0].word, "R6", "read word", 64'(rdata), 64'(exp_q[0].word));
                    void'(exp_q.pop_front());
                end
                rc = 0; lo_cnt = 0; hi_cnt = 0;
            end
            if (exp_q.size() > 0 && exp_q[0].is_rd && rc >= 47 && rc <= 62)
                mdi = exp_q[0].word[62-rc];
            else
                mdi = 1'b1;
            prev_mdc  = mdc;
            prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({mdc, mdo, oe, busy, done} == 5'b0, "R1", "reset outputs",
              64'({mdc, mdo, oe, busy, done}), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        send(1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0);
        send(1'b1, 5'h00, 5'h1F, 16'h0, 16'h8001);   // issued right after done
        send(1'b1, 5'h15, 5'h0A, 16'h0, 16'hFFFF);
        send(1'b0, 5'h0A, 5'h15, 16'h0000, 16'h0);
        send(1'b1, 5'h03, 5'h11, 16'h0, 16'h1234);

        // R9: request made during a frame is ignored
        send(1'b0, 5'h01, 5'h02, 16'h5A5A, 16'h0);
        repeat (60) @(negedge clk);
        req = 1'b1; rd = 1'b1; phy = 5'h1E; rg = 5'h1E; wd = 16'hFFFF;
        @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R9", "no frame after ignored request", 64'(busy), 64'h0);
        check(exp_q.size() == 0, "R9", "pending frames", 64'(exp_q.size()), 64'h0);
        check({mdc, oe} == 2'b00, "R8", "idle line", 64'({mdc, oe}), 64'h0);

        // R1: reset in the middle of a frame
        send(1'b1, 5'h07, 5'h07, 16'h0, 16'hBEEF);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        check({mdc, mdo, oe, busy, done} == 5'b0, "R1", "mid-frame reset",
              64'({mdc, mdo, oe, busy, done}), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        send(1'b1, 5'h12, 5'h04, 16'h0, 16'h6C39);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule